// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Line Status

This block turns an asynchronous serial line into characters and stores them in a receive queue. A 16x oversampling tick paces the sampling. Line-control inputs select the character length (5 to 8 bits), whether a parity bit is present, odd or even parity, and one or two stop bits. Each queued character carries three error tags of its own: parity error, framing error and break.

Software reads the block over a small read-only register port. A read of the data address removes the head character from the queue. A read of the status address returns an 8-bit status byte. The status byte reports the tags of the character now at the head of the queue, not the tags of the most recent arrival. Reading the status byte clears its error and overrun bits.

A break, meaning a line held low for a whole character or longer, produces exactly one zero character. A framing error is followed by resynchronisation: the low bit found in the stop position is treated as the start bit of the next character.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset the status byte reads 60h and a data read returns 00h.
- R2: A start bit is accepted only if the line is still low 8 ticks after the falling edge is seen. Each later bit is sampled 16 ticks after the one before it. Data arrives least significant bit first. The length code 0,1,2,3 selects 5,6,7,8 data bits, and data bits above the length read as 0.
- R3: When parity is enabled, the parity bit follows the data. The even-select input at 1 requires an even number of ones across data and parity, and at 0 requires an odd number. A mismatch sets the character's parity tag.
- R4: If the first stop sample is 0 and the character is not a break, the character is queued with its framing tag set and its data kept.
- R5: After a framing error, the low stop cell is taken as the next start bit. The next 16-tick cells are received as that character's data, with no new falling edge needed.
- R6: With two stop bits selected, only the first stop bit is checked. A low second stop bit sets no tag and adds no character.
- R7: If every sampled bit of a character is 0 (start, data, parity if enabled, and first stop), one character 00h with the break tag set is queued. No further character is accepted until the line returns to 1.
- R8: The status byte is read at address 5 and the data at address 0. Its bits are: bit 0 queue not empty, bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bits 5 and 6 constant 1, and bit 7 constant 0.
- R9: Status bits 4:2 show the tags of the head character. They change to the next character's tags after a data read.
- R10: A status read returns the value before the read and clears bits 4:1. The cleared error bits stay 0 until a new character reaches the head.
- R11: A character that completes while the queue is full is discarded and sets the overrun bit. Characters already in the queue are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| lc_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| lc_par_en | input | 1 | Parity bit present |
| lc_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| lc_two_stop | input | 1 | 1 = two stop bits |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |

## Verification
The hardest condition to reach is a framing error followed directly by a character that has no start edge of its own. The driver sends a frame whose stop cell is low and then continues with the next data bits and a high stop, with no idle gap. The scoreboard then expects two entries: the first with the framing tag, the second clean. The break and second-stop cases use the same approach: the line is held low across exactly the cells that must be ignored, and the bench then checks that the queue holds only the expected entries.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       bi;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2, ST_BRK
  } rx_state_t;

  localparam int unsigned ENTRY_W = 11;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int unsigned OS_RATE = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rx,
  input  logic      os_tick,
  input  logic [1:0] lc_len,
  input  logic      lc_par_en,
  input  logic      lc_par_even,
  input  logic      lc_two_stop,
  output logic      push,
  output rx_entry_t entry,
  output logic      brk_wait
);
  localparam int unsigned CW = $clog2(OS_RATE);
  localparam logic [CW-1:0] HALF_M1 = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OS_RATE - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          par_acc;
  logic          par_bit;
  logic          allz;
  logic          pe_now;
  logic [2:0]    last_idx;

  assign last_idx = 3'd4 + {1'b0, lc_len};
  assign pe_now   = lc_par_en && ((par_acc ^ par_bit) == lc_par_even);
  assign brk_wait = (state == ST_BRK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      par_bit <= 1'b0;
      allz    <= 1'b1;
      push    <= 1'b0;
      entry   <= '0;
    end else begin
      push <= 1'b0;
      if (os_tick) begin
        case (state)
          ST_IDLE: begin
            if (!rx) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == HALF_M1) begin
              cnt <= '0;
              if (!rx) begin
                state   <= ST_DATA;
                bidx    <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                par_bit <= 1'b0;
                allz    <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == FULL_M1) begin
              cnt         <= '0;
              shreg[bidx] <= rx;
              par_acc     <= par_acc ^ rx;
              allz        <= allz & ~rx;
              if (bidx == last_idx) state <= lc_par_en ? ST_PAR : ST_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == FULL_M1) begin
              cnt     <= '0;
              par_bit <= rx;
              allz    <= allz & ~rx;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == FULL_M1) begin
              cnt  <= '0;
              push <= 1'b1;
              if (rx) begin
                entry <= '{bi: 1'b0, fe: 1'b0, pe: pe_now, data: shreg};
                state <= lc_two_stop ? ST_STOP2 : ST_IDLE;
              end else if (allz) begin
                entry <= '{bi: 1'b1, fe: 1'b0, pe: 1'b0, data: 8'h00};
                state <= ST_BRK;
              end else begin
                // low stop cell becomes the next start bit
                entry   <= '{bi: 1'b0, fe: 1'b1, pe: pe_now, data: shreg};
                state   <= ST_DATA;
                bidx    <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                par_bit <= 1'b0;
                allz    <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP2: begin
            if (cnt == FULL_M1) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_BRK: begin
            if (rx) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      count;

  assign empty = (count == '0);
  assign full  = (count == DEPTH_C);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rx_entry_t  head,
  input  logic       empty,
  input  logic       pop,
  input  logic       ovr_evt,
  input  logic       lsr_rd,
  output logic       load,
  output logic [2:0] flags,
  output logic       ovr,
  output logic [7:0] lsr_val
);
  logic head_seen;

  assign load    = !empty && !head_seen;
  assign lsr_val = {1'b0, 1'b1, 1'b1, flags, ovr, !empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      head_seen <= 1'b0;
      flags     <= '0;
      ovr       <= 1'b0;
    end else begin
      if (pop)       head_seen <= 1'b0;
      else if (load) head_seen <= 1'b1;

      if (pop)         flags <= '0;
      else if (load)   flags <= {head.bi, head.fe, head.pe};
      else if (lsr_rd) flags <= '0;

      if (ovr_evt)     ovr <= 1'b1;
      else if (lsr_rd) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int unsigned OS_RATE    = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned SYNC_STG   = 2,
  parameter logic [2:0]  ADDR_DATA  = 3'd0,
  parameter logic [2:0]  ADDR_LSR   = 3'd5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic       os_tick,
  input  logic [1:0] lc_len,
  input  logic       lc_par_en,
  input  logic       lc_par_even,
  input  logic       lc_two_stop,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  output logic [7:0] reg_rdata
);
  logic [SYNC_STG-1:0] sync_q;
  logic                rx_s;

  generate
    if (SYNC_STG == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= rxd;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STG-2:0], rxd};
      end
    end
  endgenerate
  assign rx_s = sync_q[SYNC_STG-1];

  logic       core_push;
  rx_entry_t  core_entry;
  logic       core_brk;
  logic       fifo_full, fifo_empty, fifo_wr, fifo_pop;
  rx_entry_t  head_entry;
  logic       lsr_rd, st_load, st_ovr, ovr_evt;
  logic [2:0] st_flags;
  logic [7:0] lsr_val;

  uart_rx_deser #(.OS_RATE(OS_RATE)) deser_i (
    .clk(clk), .rst(rst), .rx(rx_s), .os_tick(os_tick),
    .lc_len(lc_len), .lc_par_en(lc_par_en), .lc_par_even(lc_par_even),
    .lc_two_stop(lc_two_stop), .push(core_push), .entry(core_entry),
    .brk_wait(core_brk)
  );

  assign fifo_wr  = core_push && !fifo_full;
  assign ovr_evt  = core_push && fifo_full;
  assign fifo_pop = reg_rd && (reg_addr == ADDR_DATA) && !fifo_empty;
  assign lsr_rd   = reg_rd && (reg_addr == ADDR_LSR);

  uart_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .wr_en(fifo_wr), .wr_data(core_entry),
    .rd_en(fifo_pop), .head(head_entry), .empty(fifo_empty), .full(fifo_full)
  );

  uart_rx_status status_i (
    .clk(clk), .rst(rst), .head(head_entry), .empty(fifo_empty),
    .pop(fifo_pop), .ovr_evt(ovr_evt), .lsr_rd(lsr_rd), .load(st_load),
    .flags(st_flags), .ovr(st_ovr), .lsr_val(lsr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
    end else if (reg_rd) begin
      if (fifo_pop)    reg_rdata <= head_entry.data;
      else if (lsr_rd) reg_rdata <= lsr_val;
      else             reg_rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
  input logic       clk,
  input logic       rst,
  input logic       push,
  input logic       push_bi,
  input logic       push_fe,
  input logic [7:0] push_data,
  input logic       brk_wait,
  input logic       full,
  input logic       lsr_rd,
  input logic       load,
  input logic       pop,
  input logic [2:0] flags,
  input logic       ovr
);
  AST_BREAK_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (push && push_bi) |-> (push_data == 8'h00)); // R7
  AST_ONE_BREAK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (brk_wait && $past(brk_wait)) |-> !push); // R7
  AST_BREAK_NOT_FRAMING: assert property (@(posedge clk) disable iff (rst)
    push |-> !(push_bi && push_fe)); // R4
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovr); // R11
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !(push && full)) |=> !ovr); // R10
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !load && !pop) |=> (flags == 3'b000)); // R10
endmodule

bind uart_rx_lsr uart_rx_lsr_chk chk_i (
  .clk(clk), .rst(rst), .push(core_push), .push_bi(core_entry.bi),
  .push_fe(core_entry.fe), .push_data(core_entry.data), .brk_wait(core_brk),
  .full(fifo_full), .lsr_rd(lsr_rd), .load(st_load), .pop(fifo_pop),
  .flags(st_flags), .ovr(st_ovr)
);

// File: tb/uart_rx_lsr_tb_top.sv
module uart_rx_lsr_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b1;
  logic [1:0] lc_len = 2'd3;
  logic       lc_par_en = 1'b0;
  logic       lc_par_even = 1'b0;
  logic       lc_two_stop = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [10:0] exp_q[$];  // {bi, fe, pe, data}

  always #4 clk = ~clk;  // 125 MHz

  uart_rx_lsr #(.FIFO_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick), .lc_len(lc_len),
    .lc_par_en(lc_par_en), .lc_par_even(lc_par_even), .lc_two_stop(lc_two_stop),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_data_bits(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
  endtask

  // driver: sends one frame and pushes the expected entry
  task automatic send_frame(input logic [7:0] d, input int n, input logic bad_par,
                            input logic stop1, input logic stop2, input int idle);
    logic p;
    logic [7:0] m;
    m = d & 8'((1 << n) - 1);
    p = ^m;
    if (!lc_par_even) p = ~p;
    if (bad_par) p = ~p;
    drive_bit(1'b0);
    send_data_bits(m, n);
    if (lc_par_en) drive_bit(p);
    drive_bit(stop1);
    if (lc_two_stop) drive_bit(stop2);
    for (int i = 0; i < idle; i++) drive_bit(1'b1);
    exp_q.push_back({1'b0, ~stop1, bad_par & lc_par_en, m});
  endtask

  // monitor: pops the expected head and compares status then data
  task automatic check_head(input string req);
    logic [7:0] d;
    logic [10:0] e;
    e = exp_q.pop_front();
    reg_read(3'd5, d);
    check({req, " status"}, d & 8'h1D, {3'b000, e[10:8], 2'b01});
    reg_read(3'd0, d);
    check({req, " data"}, d, e[7:0]);
  endtask

  task automatic check_empty(input string req);
    logic [7:0] d;
    reg_read(3'd5, d);
    check({req, " empty"}, d & 8'h01, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state, R8 layout
    reg_read(3'd5, d); check("R1 lsr reset", d, 8'h60);
    reg_read(3'd0, d); check("R1 data reset", d, 8'h00);

    // R2 8-bit and 5-bit characters
    send_frame(8'hA5, 8, 1'b0, 1'b1, 1'b1, 2);
    check_head("R2 8N1");
    lc_len = 2'd0;
    send_frame(8'hF5, 5, 1'b0, 1'b1, 1'b1, 2);
    check_head("R2 5N1");

    // R3 parity, even and odd
    lc_len = 2'd2; lc_par_en = 1'b1; lc_par_even = 1'b1;
    send_frame(8'h35, 7, 1'b0, 1'b1, 1'b1, 2);
    check_head("R3 even ok");
    send_frame(8'h35, 7, 1'b1, 1'b1, 1'b1, 2);
    check_head("R3 even bad");
    lc_par_even = 1'b0;
    send_frame(8'h4C, 7, 1'b1, 1'b1, 1'b1, 2);
    check_head("R3 odd bad");
    send_frame(8'h4C, 7, 1'b0, 1'b1, 1'b1, 2);
    check_head("R3 odd ok");

    // R4 framing error, R5 resync without a new start edge
    lc_len = 2'd3; lc_par_en = 1'b0;
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1, 0);
    send_data_bits(8'h5A, 8);
    drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1);
    exp_q.push_back({3'b000, 8'h5A});
    check_head("R4 framing");
    check_head("R5 resync");
    check_empty("R5");

    // R6 second stop bit ignored
    lc_two_stop = 1'b1;
    send_frame(8'h81, 8, 1'b0, 1'b1, 1'b0, 2);
    check_head("R6 two stop");
    check_empty("R6");
    lc_two_stop = 1'b0;

    // R7 break gives one zero entry
    rxd = 1'b0;
    repeat (20 * 16) @(negedge clk);
    drive_bit(1'b1); drive_bit(1'b1);
    exp_q.push_back({3'b100, 8'h00});
    check_head("R7 break");
    check_empty("R7");

    // R9 head tags, R10 clear on read
    lc_par_en = 1'b1; lc_par_even = 1'b1;
    send_frame(8'h11, 8, 1'b1, 1'b1, 1'b1, 1);
    send_frame(8'h22, 8, 1'b0, 1'b1, 1'b1, 2);
    reg_read(3'd5, d); check("R9 head pe", d, 8'h65);
    reg_read(3'd5, d); check("R10 cleared", d, 8'h61);
    reg_read(3'd0, d); check("R9 pop first", d, 8'h11);
    reg_read(3'd5, d); check("R9 next head", d, 8'h61);
    reg_read(3'd0, d); check("R9 pop second", d, 8'h22);
    exp_q.delete();

    // R11 overrun with a four-entry queue
    lc_par_en = 1'b0;
    for (int i = 0; i < 5; i++) send_frame(8'(8'h40 + i), 8, 1'b0, 1'b1, 1'b1, 1);
    drive_bit(1'b1);
    void'(exp_q.pop_back());
    reg_read(3'd5, d); check("R11 overrun", d, 8'h63);
    reg_read(3'd5, d); check("R10 overrun cleared", d, 8'h61);
    for (int i = 0; i < 4; i++) check_head("R11 kept");
    check_empty("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule